// File: doc/BRIEF.md
# Pivot and Nonpivot Fault CAM

This block gathers the failing cell addresses that a built-in self-test engine reports while it runs. It takes at most one fault per clock and decides in that same clock where the fault belongs. A fault whose row and whose column are both unseen starts a new entry in the pivot table. A fault that lines up with an already stored pivot, on its row or on its column, goes into the nonpivot table instead. The nonpivot entry does not repeat the shared address: it keeps a pointer to the pivot line, a bit that says which address is shared, the address that is not shared, and its own block number.

A fault counts as lined up with a pivot when it is in the pivot's own block or in the partner block, meaning the block number with bit 0 inverted. For every pivot line the block counts how many faults share its row or column, in the same block and in the partner block. It raises must-repair flags once a line holds more faults than the spares in the crossing direction can cover. When the test-finished input is asserted, collection stops and both tables are frozen so a later analysis stage can read them. The spare allocator that reads the tables is a separate block.

Top module: `fault_cam`

## Requirements
- R1: Reset (synchronous, active high) clears every pivot and nonpivot enable flag, the overflow flag and the analysis-phase flag, and sets every must-repair counter to zero.
- R2: A valid fault that matches no stored pivot row or column is written to the lowest free pivot line. That line's enable flag, row, column and block are visible on the outputs one clock later.
- R3: A fault that needs a table with no free line is dropped and sets `overflow`, which stays high until reset.
- R4: A fault matches a pivot line on its row (or column) when the addresses are equal and the fault's block equals the pivot's block or the pivot's block with bit 0 inverted. Such a fault is written to the lowest free nonpivot line. Row matches take priority over column matches, and lower pivot lines take priority over higher ones.
- R5: A nonpivot line holds four fields. The pointer names the matched pivot line. The type bit is 0 when the row is shared and 1 when the column is shared. The address field holds the column (type 0) or the row (type 1), zero-extended. The block field holds the fault's own block.
- R6: A fault whose row, column and block all equal one stored pivot is a duplicate. It is dropped, and no table or counter changes.
- R7: The must-repair flags of pivot line i are `pv_must[4*i+3:4*i]`. Bit 0 is set when, counting the pivot itself, the faults in its block on its row outnumber `SPARE_COLS`. Bit 1 is set when the faults in its block on its column outnumber `SPARE_ROWS`.
- R8: Bit 2 of a line's must-repair flags is set when more than `SPARE_COLS` partner-block faults share its row. Bit 3 is set when more than `SPARE_ROWS` partner-block faults share its column.
- R9: `test_done` sets `analyzing` on the next clock. From then on no fault is stored and neither the enable flags nor `overflow` change until reset.
- R10: Faults may arrive on consecutive clocks with no stall. Each stored fault is taken into account when the fault on the next clock is matched, and at most one line is written per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | A fault is presented this clock |
| flt_row | input | ROW_W | Fault row address |
| flt_col | input | COL_W | Fault column address |
| flt_blk | input | BLK_W | Fault block address |
| test_done | input | 1 | Self-test finished; enter analysis phase |
| analyzing | output | 1 | Analysis phase active, tables frozen |
| overflow | output | 1 | A fault was lost because its table was full |
| pv_en | output | PV_DEPTH | Pivot line enable flags |
| pv_row | output | PV_DEPTH*ROW_W | Pivot row addresses, line i at bits [i*ROW_W +: ROW_W] |
| pv_col | output | PV_DEPTH*COL_W | Pivot column addresses |
| pv_blk | output | PV_DEPTH*BLK_W | Pivot block addresses |
| pv_must | output | PV_DEPTH*4 | Must-repair flags, four per pivot line |
| np_en | output | NP_DEPTH | Nonpivot line enable flags |
| np_ptr | output | NP_DEPTH*PA_W | Pointer to the shared pivot line |
| np_type | output | NP_DEPTH | Shared address type: 0 row, 1 column |
| np_addr | output | NP_DEPTH*AD_W | Non-shared address |
| np_blk | output | NP_DEPTH*BLK_W | Nonpivot fault block |

## Verification
The main stream sends fresh addresses, row-sharing and column-sharing faults, an exact duplicate, and partner-block faults back to back. This separates the pivot path from the nonpivot path, row priority from column priority, and lower-line priority from higher-line priority. One fault has the same row and column as a stored pivot but sits in a block that is neither that pivot's block nor its partner. It must become a new pivot, which shows that block distance is part of the match. The must-repair flags are read one fault before and one fault after each threshold is crossed. Further tests fill each table to the brim and assert `test_done`, which shows that faults are dropped and the tables frozen.

// File: rtl/fault_cam_pkg.sv
package fault_cam_pkg;
  localparam int MUST_W       = 4;
  localparam int MUST_ROW     = 0;
  localparam int MUST_COL     = 1;
  localparam int MUST_ADJ_ROW = 2;
  localparam int MUST_ADJ_COL = 3;

  typedef enum logic [1:0] {
    ACT_IGNORE,
    ACT_PIVOT,
    ACT_SHARED,
    ACT_LOST
  } act_e;
endpackage

// File: rtl/fault_cam_match.sv
module fault_cam_match #(
  parameter int P     = 4,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int BLK_W = 2,
  parameter int PA_W  = 2
) (
  input  logic [P-1:0]       pv_en,
  input  logic [ROW_W-1:0]   pv_row [P],
  input  logic [COL_W-1:0]   pv_col [P],
  input  logic [BLK_W-1:0]   pv_blk [P],
  input  logic [ROW_W-1:0]   row,
  input  logic [COL_W-1:0]   col,
  input  logic [BLK_W-1:0]   blk,
  output logic               dup,
  output logic               hit,
  output logic               hit_col,
  output logic [PA_W-1:0]    hit_idx,
  output logic               hit_adj
);
  localparam logic [BLK_W-1:0] PARTNER = BLK_W'(1);

  logic [P-1:0] row_hit, col_hit, same_blk, dup_hit;
  logic [PA_W-1:0] ridx, cidx;

  always_comb begin
    for (int i = 0; i < P; i++) begin
      same_blk[i] = (blk == pv_blk[i]);
      row_hit[i]  = pv_en[i] && (row == pv_row[i]) &&
                    (same_blk[i] || (blk == (pv_blk[i] ^ PARTNER)));
      col_hit[i]  = pv_en[i] && (col == pv_col[i]) &&
                    (same_blk[i] || (blk == (pv_blk[i] ^ PARTNER)));
      dup_hit[i]  = pv_en[i] && same_blk[i] && (row == pv_row[i]) && (col == pv_col[i]);
    end
    ridx = '0;
    cidx = '0;
    for (int i = P - 1; i >= 0; i--) begin
      if (row_hit[i]) ridx = PA_W'(i);
      if (col_hit[i]) cidx = PA_W'(i);
    end
    dup     = |dup_hit;
    hit     = (|row_hit) || (|col_hit);
    hit_col = !(|row_hit);
    hit_idx = (|row_hit) ? ridx : cidx;
    hit_adj = !same_blk[hit_idx];
  end
endmodule

// File: rtl/fault_cam_must.sv
module fault_cam_must
  import fault_cam_pkg::*;
#(
  parameter int P          = 4,
  parameter int PA_W       = 2,
  parameter int CNT_W      = 4,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [PA_W-1:0]   inc_idx,
  input  logic              inc_col,
  input  logic              inc_adj,
  output logic [P*MUST_W-1:0] must
);
  localparam logic [CNT_W-1:0] LIM_R = CNT_W'(SPARE_ROWS);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(SPARE_COLS);

  for (genvar i = 0; i < P; i++) begin : g_line
    logic [CNT_W-1:0] cnt [MUST_W];
    logic [MUST_W-1:0] sel;

    always_comb begin
      sel = '0;
      if (inc && inc_idx == PA_W'(i))
        sel[{inc_adj, inc_col}] = 1'b1;
    end

    for (genvar k = 0; k < MUST_W; k++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) cnt[k] <= '0;
        else if (sel[k]) cnt[k] <= cnt[k] + CNT_W'(1);
      end
    end

    // Same-block counts exclude the pivot itself, hence >= for "more than".
    assign must[i*MUST_W + MUST_ROW]     = cnt[MUST_ROW] >= LIM_C;
    assign must[i*MUST_W + MUST_COL]     = cnt[MUST_COL] >= LIM_R;
    assign must[i*MUST_W + MUST_ADJ_ROW] = cnt[MUST_ADJ_ROW] > LIM_C;
    assign must[i*MUST_W + MUST_ADJ_COL] = cnt[MUST_ADJ_COL] > LIM_R;
  end
endmodule

// File: rtl/fault_cam.sv
module fault_cam
  import fault_cam_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int BLK_W      = 2,
  parameter int PV_DEPTH   = 4,
  parameter int NP_DEPTH   = 8,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  localparam int PA_W = (PV_DEPTH > 1) ? $clog2(PV_DEPTH) : 1,
  localparam int AD_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flt_valid,
  input  logic [ROW_W-1:0]            flt_row,
  input  logic [COL_W-1:0]            flt_col,
  input  logic [BLK_W-1:0]            flt_blk,
  input  logic                        test_done,
  output logic                        analyzing,
  output logic                        overflow,
  output logic [PV_DEPTH-1:0]         pv_en,
  output logic [PV_DEPTH*ROW_W-1:0]   pv_row,
  output logic [PV_DEPTH*COL_W-1:0]   pv_col,
  output logic [PV_DEPTH*BLK_W-1:0]   pv_blk,
  output logic [PV_DEPTH*4-1:0]       pv_must,
  output logic [NP_DEPTH-1:0]         np_en,
  output logic [NP_DEPTH*PA_W-1:0]    np_ptr,
  output logic [NP_DEPTH-1:0]         np_type,
  output logic [NP_DEPTH*AD_W-1:0]    np_addr,
  output logic [NP_DEPTH*BLK_W-1:0]   np_blk
);
  localparam int PC_W  = $clog2(PV_DEPTH + 1);
  localparam int NC_W  = $clog2(NP_DEPTH + 1);
  localparam int NA_W  = (NP_DEPTH > 1) ? $clog2(NP_DEPTH) : 1;
  localparam int CNT_W = $clog2(NP_DEPTH + 2);

  logic [ROW_W-1:0] pv_row_q [PV_DEPTH];
  logic [COL_W-1:0] pv_col_q [PV_DEPTH];
  logic [BLK_W-1:0] pv_blk_q [PV_DEPTH];
  logic [PA_W-1:0]  np_ptr_q [NP_DEPTH];
  logic             np_type_q [NP_DEPTH];
  logic [AD_W-1:0]  np_addr_q [NP_DEPTH];
  logic [BLK_W-1:0] np_blk_q [NP_DEPTH];

  logic [PC_W-1:0] pv_cnt;
  logic [NC_W-1:0] np_cnt;
  logic pv_full, np_full;
  logic dup, hit, hit_col, hit_adj;
  logic [PA_W-1:0] hit_idx;
  act_e act;

  assign pv_full = (pv_cnt == PC_W'(PV_DEPTH));
  assign np_full = (np_cnt == NC_W'(NP_DEPTH));

  fault_cam_match #(
    .P(PV_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .BLK_W(BLK_W), .PA_W(PA_W)
  ) u_match (
    .pv_en(pv_en), .pv_row(pv_row_q), .pv_col(pv_col_q), .pv_blk(pv_blk_q),
    .row(flt_row), .col(flt_col), .blk(flt_blk),
    .dup(dup), .hit(hit), .hit_col(hit_col), .hit_idx(hit_idx), .hit_adj(hit_adj)
  );

  always_comb begin
    act = ACT_IGNORE;
    if (flt_valid && !analyzing && !dup) begin
      if (hit) act = np_full ? ACT_LOST : ACT_SHARED;
      else     act = pv_full ? ACT_LOST : ACT_PIVOT;
    end
  end

  // Control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      analyzing <= 1'b0;
      overflow  <= 1'b0;
      pv_en     <= '0;
      np_en     <= '0;
      pv_cnt    <= '0;
      np_cnt    <= '0;
    end else begin
      if (test_done) analyzing <= 1'b1;
      unique case (act)
        ACT_PIVOT: begin
          pv_en[PA_W'(pv_cnt)] <= 1'b1;
          pv_cnt <= pv_cnt + PC_W'(1);
        end
        ACT_SHARED: begin
          np_en[NA_W'(np_cnt)] <= 1'b1;
          np_cnt <= np_cnt + NC_W'(1);
        end
        ACT_LOST:   overflow <= 1'b1;
        default:    ;
      endcase
    end
  end

  // Table storage, write-only by index, no reset (RAM style)
  always_ff @(posedge clk) begin
    if (act == ACT_PIVOT) begin
      pv_row_q[PA_W'(pv_cnt)] <= flt_row;
      pv_col_q[PA_W'(pv_cnt)] <= flt_col;
      pv_blk_q[PA_W'(pv_cnt)] <= flt_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_SHARED) begin
      np_ptr_q[NA_W'(np_cnt)]  <= hit_idx;
      np_type_q[NA_W'(np_cnt)] <= hit_col;
      np_addr_q[NA_W'(np_cnt)] <= hit_col ? AD_W'(flt_row) : AD_W'(flt_col);
      np_blk_q[NA_W'(np_cnt)]  <= flt_blk;
    end
  end

  fault_cam_must #(
    .P(PV_DEPTH), .PA_W(PA_W), .CNT_W(CNT_W),
    .SPARE_ROWS(SPARE_ROWS), .SPARE_COLS(SPARE_COLS)
  ) u_must (
    .clk(clk), .rst(rst), .inc(act == ACT_SHARED),
    .inc_idx(hit_idx), .inc_col(hit_col), .inc_adj(hit_adj),
    .must(pv_must)
  );

  for (genvar i = 0; i < PV_DEPTH; i++) begin : g_pv_out
    assign pv_row[i*ROW_W +: ROW_W] = pv_row_q[i];
    assign pv_col[i*COL_W +: COL_W] = pv_col_q[i];
    assign pv_blk[i*BLK_W +: BLK_W] = pv_blk_q[i];
  end

  for (genvar j = 0; j < NP_DEPTH; j++) begin : g_np_out
    assign np_ptr[j*PA_W +: PA_W]   = np_ptr_q[j];
    assign np_type[j]               = np_type_q[j];
    assign np_addr[j*AD_W +: AD_W]  = np_addr_q[j];
    assign np_blk[j*BLK_W +: BLK_W] = np_blk_q[j];
  end
endmodule

// File: rtl/fault_cam_chk.sv
module fault_cam_chk #(
  parameter int PV_DEPTH = 4,
  parameter int NP_DEPTH = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  flt_valid,
  input logic                  analyzing,
  input logic                  overflow,
  input logic [PV_DEPTH-1:0]   pv_en,
  input logic [NP_DEPTH-1:0]   np_en,
  input logic [PV_DEPTH*4-1:0] pv_must
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pv_en == '0 && np_en == '0 && !overflow && !analyzing && pv_must == '0));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(overflow));

  assert_phase_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$fell(analyzing));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    analyzing |=> ($stable(pv_en) && $stable(np_en) && $stable(overflow)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !flt_valid |=> ($stable(pv_en) && $stable(np_en)));

  assert_one_store_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(pv_en ^ $past(pv_en)) + $countones(np_en ^ $past(np_en))) <= 1);

  assert_pivot_order_R2: assert property (@(posedge clk) disable iff (rst)
    ((pv_en + PV_DEPTH'(1)) & pv_en) == '0);

  for (genvar i = 0; i < PV_DEPTH; i++) begin : g_must
    assert_must_on_line_R7: assert property (@(posedge clk) disable iff (rst)
      (|pv_must[i*4 +: 4]) |-> pv_en[i]);
  end
endmodule

bind fault_cam fault_cam_chk #(
  .PV_DEPTH(PV_DEPTH), .NP_DEPTH(NP_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .analyzing(analyzing),
  .overflow(overflow), .pv_en(pv_en), .np_en(np_en), .pv_must(pv_must)
);

// File: tb/fault_cam_tb.sv
`timescale 1ns/1ps
module fault_cam_tb;
  localparam int RW = 4, CW = 4, BW = 2, PD = 4, ND = 8, PA = 2, AD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic flt_valid = 1'b0, test_done = 1'b0;
  logic [RW-1:0] flt_row = '0;
  logic [CW-1:0] flt_col = '0;
  logic [BW-1:0] flt_blk = '0;
  logic analyzing, overflow;
  logic [PD-1:0] pv_en;
  logic [PD*RW-1:0] pv_row;
  logic [PD*CW-1:0] pv_col;
  logic [PD*BW-1:0] pv_blk;
  logic [PD*4-1:0] pv_must;
  logic [ND-1:0] np_en, np_type;
  logic [ND*PA-1:0] np_ptr;
  logic [ND*AD-1:0] np_addr;
  logic [ND*BW-1:0] np_blk;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_cam #(.ROW_W(RW), .COL_W(CW), .BLK_W(BW), .PV_DEPTH(PD), .NP_DEPTH(ND),
              .SPARE_ROWS(2), .SPARE_COLS(2)) u_dut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_row(flt_row), .flt_col(flt_col),
    .flt_blk(flt_blk), .test_done(test_done), .analyzing(analyzing), .overflow(overflow),
    .pv_en(pv_en), .pv_row(pv_row), .pv_col(pv_col), .pv_blk(pv_blk), .pv_must(pv_must),
    .np_en(np_en), .np_ptr(np_ptr), .np_type(np_type), .np_addr(np_addr), .np_blk(np_blk));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Fields: row[21:18] col[17:14] blk[13:12] kind[11:10] idx[9:7] ptr[6:5] type[4] must0[3:0]
  // kind 0 = new pivot, 1 = shared (nonpivot), 2 = dropped
  localparam logic [21:0] VEC [12] = '{
    {4'd1, 4'd1,  2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 4'h0},
    {4'd1, 4'd5,  2'd0, 2'd1, 3'd0, 2'd0, 1'b0, 4'h0},
    {4'd7, 4'd1,  2'd0, 2'd1, 3'd1, 2'd0, 1'b1, 4'h0},
    {4'd1, 4'd1,  2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 4'h0},
    {4'd2, 4'd2,  2'd1, 2'd0, 3'd1, 2'd0, 1'b0, 4'h0},
    {4'd2, 4'd9,  2'd0, 2'd1, 3'd2, 2'd1, 1'b0, 4'h0},
    {4'd3, 4'd3,  2'd2, 2'd0, 3'd2, 2'd0, 1'b0, 4'h0},
    {4'd3, 4'd3,  2'd0, 2'd0, 3'd3, 2'd0, 1'b0, 4'h0},
    {4'd1, 4'd2,  2'd0, 2'd1, 3'd3, 2'd0, 1'b0, 4'h1},
    {4'd2, 4'd10, 2'd0, 2'd1, 3'd4, 2'd1, 1'b0, 4'h1},
    {4'd2, 4'd11, 2'd0, 2'd1, 3'd5, 2'd1, 1'b0, 4'h1},
    {4'd8, 4'd1,  2'd0, 2'd1, 3'd6, 2'd0, 1'b1, 4'h3}
  };

  task automatic do_reset();
    rst = 1'b1; flt_valid = 1'b0; test_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input int r, input int c, input int b);
    flt_row = RW'(r); flt_col = CW'(c); flt_blk = BW'(b); flt_valid = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  initial begin
    int npv, nnp;
    do_reset();
    chk("R1 reset pv_en", 32'(pv_en), 0);
    chk("R1 reset np_en", 32'(np_en), 0);
    chk("R1 reset overflow/analyzing", {30'd0, overflow, analyzing}, 0);
    chk("R1 reset must", 32'(pv_must), 0);

    // Back-to-back stream (R10): valid held high across the whole table
    npv = 0; nnp = 0;
    for (int i = 0; i < 12; i++) begin
      logic [21:0] v;
      int idx;
      v = VEC[i];
      idx = int'(v[9:7]);
      flt_row = v[21:18]; flt_col = v[17:14]; flt_blk = v[13:12]; flt_valid = 1'b1;
      @(negedge clk);
      if (v[11:10] == 2'd0) begin
        npv++;
        chk($sformatf("R2 vec%0d pivot row", i), 32'(pv_row[idx*RW +: RW]), 32'(v[21:18]));
        chk($sformatf("R2 vec%0d pivot col", i), 32'(pv_col[idx*CW +: CW]), 32'(v[17:14]));
        chk($sformatf("R2 vec%0d pivot blk", i), 32'(pv_blk[idx*BW +: BW]), 32'(v[13:12]));
      end else if (v[11:10] == 2'd1) begin
        nnp++;
        chk($sformatf("R4 vec%0d ptr", i), 32'(np_ptr[idx*PA +: PA]), 32'(v[6:5]));
        chk($sformatf("R5 vec%0d type", i), 32'(np_type[idx]), 32'(v[4]));
        chk($sformatf("R5 vec%0d addr", i), 32'(np_addr[idx*AD +: AD]),
            v[4] ? 32'(v[21:18]) : 32'(v[17:14]));
        chk($sformatf("R5 vec%0d blk", i), 32'(np_blk[idx*BW +: BW]), 32'(v[13:12]));
      end
      chk($sformatf("R10 vec%0d pv_en (R6 on drop)", i), 32'(pv_en), (32'd1 << npv) - 1);
      chk($sformatf("R10 vec%0d np_en (R6 on drop)", i), 32'(np_en), (32'd1 << nnp) - 1);
      chk($sformatf("R7 vec%0d line0 must", i), 32'(pv_must[3:0]), 32'(v[3:0]));
    end
    flt_valid = 1'b0;
    chk("R8 line1 partner-row must", 32'(pv_must[7:4]), 32'h4);
    chk("R7 line2/3 no must", 32'(pv_must[15:8]), 0);
    chk("R3 no overflow yet", 32'(overflow), 0);

    // Pivot table full: fresh address is lost
    send(9, 9, 0);
    chk("R3 pivot overflow flag", 32'(overflow), 1);
    chk("R3 pivot table unchanged", 32'(pv_en), 32'hF);
    send(4, 4, 0);
    chk("R3 overflow sticky", 32'(overflow), 1);

    // Reset clears state after use
    do_reset();
    chk("R1 re-reset pv_en", 32'(pv_en), 0);
    chk("R1 re-reset overflow", 32'(overflow), 0);
    chk("R1 re-reset must", 32'(pv_must), 0);

    // Freeze on test_done
    send(4, 4, 0);
    chk("R2 fresh pivot after reset", 32'(pv_en), 1);
    test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
    chk("R9 analyzing set", 32'(analyzing), 1);
    send(5, 5, 0);
    send(4, 6, 0);
    chk("R9 pivot frozen", 32'(pv_en), 1);
    chk("R9 nonpivot frozen", 32'(np_en), 0);
    chk("R9 overflow unchanged", 32'(overflow), 0);

    // Nonpivot table full
    do_reset();
    send(0, 0, 0);
    for (int k = 1; k <= ND; k++) send(0, k, 0);
    chk("R3 np table full", 32'(np_en), 32'hFF);
    chk("R3 no overflow at exact fill", 32'(overflow), 0);
    send(0, 9, 0);
    chk("R3 np overflow flag", 32'(overflow), 1);
    chk("R3 np table intact", 32'(np_en), 32'hFF);
    chk("R3 pivot table intact", 32'(pv_en), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule